// File: doc/BRIEF.md
# Page-Table Entry Flag Updater

This block takes a leaf page-table entry after an access to the page has already been permitted. It decides whether the entry has to be written back and, if so, builds the new entry. Beside the usual accessed (A) and dirty (D) flags, the entry has a 10-bit extension field with a separate capability-dirty flag. Only stores of tagged capabilities set that flag, and only when capability writes are allowed on the page.

When a write-back is needed, the block issues one compare-and-swap request to memory. The request carries the entry as it was read and the entry to store. The block then waits for the memory's verdict. If another agent changed the entry in the meantime, the swap fails and the block reports a retry to its requester instead of treating the update as done. When no flag changes, no memory request is made and the result returns at once.

The request and result sides are valid/ready streams. A request is taken only while the block is idle, and then one transaction is in flight at a time. The swap request holds its payload until `cas_ready`. The result holds its payload until `res_ready`. Any of these may be stalled for any number of cycles.

Top module: `pte_flag_updater`

## Requirements
- R1: When flag A (bit 6 of the base flags) is 0, an update is needed. In every entry that is updated, A is 1.
- R2: D (bit 7) is set when the access has a write side (write or read-modify-write) and D is 0. Execute and read accesses never set D.
- R3: Capability-dirty (extension bit 7) is set when capability-write-permit (extension bit 9) is 1, capability-dirty is 0, and the access has a capability write side carrying a valid tag (`in_tag`=1).
- R4: A capability write side whose data has no valid tag (`in_tag`=0) counts as a data write and never sets capability-dirty.
- R5: Every bit other than A, D and capability-dirty keeps its value. This covers V, R, W, X, U and G (bits 0 to 5), capability-read-permit (extension bit 8) and extension bits 0 to 6.
- R6: When none of A, D or capability-dirty needs updating, no swap request is issued. The result has `res_upd`=0 and the unchanged entry, and `res_valid` rises on the cycle after the request is accepted.
- R7: When an update is needed, `cas_valid` rises on the cycle after acceptance. `cas_expect` is {extension, flags} as read and `cas_new` is the updated entry. Both stay stable until `cas_ready`.
- R8: After the swap is accepted, a `mem_done` pulse completes it. `mem_ok`=0 gives `res_retry`=1 and `mem_ok`=1 gives `res_retry`=0. The result shows on the cycle after the pulse.
- R9: When `no_ext`=1, the extension field is taken as the constant 0b1110000000 whatever `in_ext` holds, so capability-dirty is never newly set.
- R10: `in_ready` is high only while no transaction is in flight. A presented result stays valid and unchanged until `res_ready`.
- R11: `in_acc` is {kind[1:0], read-side capability, write-side capability}. The kind codes are 0 execute, 1 read, 2 write and 3 read-modify-write. Execute carries no capability bits, a read has no write-side bit, and a write has no read-side bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_ext | input | 1 | No extension bits exist; use the fixed extension value |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted while high |
| in_flags | input | 8 | Base flags as read: V R W X U G A D, bits 0 to 7 |
| in_ext | input | 10 | Extension field as read |
| in_acc | input | 4 | Access code (see R11) |
| in_tag | input | 1 | Store data carries a valid capability tag |
| cas_valid | output | 1 | Swap request valid |
| cas_ready | input | 1 | Memory accepts the swap request |
| cas_expect | output | 18 | Entry expected in memory, {ext, flags} |
| cas_new | output | 18 | Entry to store, {ext, flags} |
| mem_done | input | 1 | Swap completed (one-cycle pulse) |
| mem_ok | input | 1 | Swap succeeded; qualified by mem_done |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Requester takes the result |
| res_upd | output | 1 | A write-back was needed |
| res_retry | output | 1 | The swap lost a race; redo the access |
| res_flags | output | 8 | New base flags |
| res_ext | output | 10 | New extension field |

## Verification
Every output is registered. After the edge that accepts a request, the next falling edge shows either the swap request or, when no update is needed, the result. The swap is handed over at a `cas_ready` edge. The result follows one cycle after the `mem_done` edge. The bench drives inputs on falling edges and samples at the falling edge after each of these events. It also samples again while holding `cas_ready` or `res_ready` low, to see that the payload has not moved.

// File: rtl/pte_upd_pkg.sv
package pte_upd_pkg;
  localparam int FLAG_W  = 8;
  localparam int EXT_W   = 10;
  localparam int ENTRY_W = FLAG_W + EXT_W;
  localparam int F_A     = 6;
  localparam int F_D     = 7;
  localparam int X_CW    = 9;
  localparam int X_CD    = 7;
  localparam logic [EXT_W-1:0] NARROW_EXT = 10'b1110000000;

  typedef enum logic [1:0] {K_EXEC = 2'd0, K_READ = 2'd1, K_WRITE = 2'd2, K_RMW = 2'd3} kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CAS, ST_WAIT, ST_RSP} state_e;

  typedef struct packed {
    logic              upd;
    logic [EXT_W-1:0]  ext;
    logic [FLAG_W-1:0] flags;
  } upd_t;
endpackage

// File: rtl/pte_upd_calc.sv
module pte_upd_calc
  import pte_upd_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [EXT_W-1:0]  ext,
  input  logic [1:0]        kind,
  input  logic              wr_cap,
  input  logic              tag,
  input  logic              no_ext,
  output logic [EXT_W-1:0]  ext_eff,
  output upd_t              res
);
  logic wr_side, cap_store, need_a, need_d, need_cd;

  always_comb begin
    ext_eff   = no_ext ? NARROW_EXT : ext;
    wr_side   = (kind == K_WRITE) || (kind == K_RMW);
    cap_store = wr_side && wr_cap && tag;
    need_a    = !flags[F_A];
    need_d    = wr_side && !flags[F_D];
    need_cd   = ext_eff[X_CW] && !ext_eff[X_CD] && cap_store;
    res.upd   = need_a || need_d || need_cd;
    res.flags = flags;
    res.ext   = ext_eff;
    if (res.upd) res.flags[F_A] = 1'b1;
    if (need_d)  res.flags[F_D] = 1'b1;
    if (need_cd) res.ext[X_CD]  = 1'b1;
  end
endmodule

// File: rtl/pte_upd_ctrl.sv
module pte_upd_ctrl
  import pte_upd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FLAG_W-1:0]  old_flags,
  input  logic [EXT_W-1:0]   old_ext,
  input  upd_t               calc,
  output logic               cas_valid,
  input  logic               cas_ready,
  output logic [ENTRY_W-1:0] cas_expect,
  output logic [ENTRY_W-1:0] cas_new,
  input  logic               mem_done,
  input  logic               mem_ok,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_upd,
  output logic               res_retry,
  output logic [FLAG_W-1:0]  res_flags,
  output logic [EXT_W-1:0]   res_ext
);
  state_e             st;
  logic [ENTRY_W-1:0] old_q, new_q;
  logic               upd_q, retry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      old_q   <= '0;
      new_q   <= '0;
      upd_q   <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (in_valid) begin
          old_q   <= {old_ext, old_flags};
          new_q   <= {calc.ext, calc.flags};
          upd_q   <= calc.upd;
          retry_q <= 1'b0;
          st      <= calc.upd ? ST_CAS : ST_RSP;
        end
        ST_CAS:  if (cas_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_done) begin
          retry_q <= !mem_ok;
          st      <= ST_RSP;
        end
        default: if (res_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (st == ST_IDLE);
  assign cas_valid  = (st == ST_CAS);
  assign res_valid  = (st == ST_RSP);
  assign cas_expect = old_q;
  assign cas_new    = new_q;
  assign res_upd    = upd_q;
  assign res_retry  = retry_q;
  assign res_flags  = new_q[FLAG_W-1:0];
  assign res_ext    = new_q[ENTRY_W-1:FLAG_W];

  assert_cas_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid && !cas_ready |=> cas_valid && $stable(cas_new) && $stable(cas_expect));
  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable({res_upd, res_retry, res_flags, res_ext}));
  assert_swap_changes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid |-> cas_new != cas_expect);
  assert_a_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_upd |-> res_flags[F_A]);
  assert_cd_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid && cas_new[FLAG_W+X_CD] && !cas_expect[FLAG_W+X_CD] |-> cas_expect[FLAG_W+X_CW]);
  assert_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_retry |-> res_upd);
endmodule

// File: rtl/pte_flag_updater.sv
module pte_flag_updater
  import pte_upd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               no_ext,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FLAG_W-1:0]  in_flags,
  input  logic [EXT_W-1:0]   in_ext,
  input  logic [3:0]         in_acc,
  input  logic               in_tag,
  output logic               cas_valid,
  input  logic               cas_ready,
  output logic [ENTRY_W-1:0] cas_expect,
  output logic [ENTRY_W-1:0] cas_new,
  input  logic               mem_done,
  input  logic               mem_ok,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_upd,
  output logic               res_retry,
  output logic [FLAG_W-1:0]  res_flags,
  output logic [EXT_W-1:0]   res_ext
);
  upd_t             calc;
  logic [EXT_W-1:0] ext_eff;

  pte_upd_calc u_calc (
    .flags(in_flags), .ext(in_ext), .kind(in_acc[3:2]), .wr_cap(in_acc[0]),
    .tag(in_tag), .no_ext(no_ext), .ext_eff(ext_eff), .res(calc)
  );

  pte_upd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .old_flags(in_flags), .old_ext(ext_eff), .calc(calc),
    .cas_valid(cas_valid), .cas_ready(cas_ready), .cas_expect(cas_expect), .cas_new(cas_new),
    .mem_done(mem_done), .mem_ok(mem_ok),
    .res_valid(res_valid), .res_ready(res_ready), .res_upd(res_upd), .res_retry(res_retry),
    .res_flags(res_flags), .res_ext(res_ext)
  );

  // R11: legal access codes only on an accepted request
  always_comb begin
    if (rst_n && in_valid && in_ready) begin
      assert_code_legal_R11: assert (
        !((in_acc[3:2] == K_EXEC)  && (in_acc[1] || in_acc[0])) &&
        !((in_acc[3:2] == K_READ)  && in_acc[0]) &&
        !((in_acc[3:2] == K_WRITE) && in_acc[1]))
        else $error("illegal access code %b", in_acc);
    end
  end
endmodule

// File: tb/sim_pte_flag_updater.sv
module sim_pte_flag_updater;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic no_ext = 1'b0, in_valid = 1'b0, in_tag = 1'b0;
  logic [7:0] in_flags = '0;
  logic [9:0] in_ext = '0;
  logic [3:0] in_acc = '0;
  logic cas_ready = 1'b0, mem_done = 1'b0, mem_ok = 1'b0, res_ready = 1'b0;
  logic in_ready, cas_valid, res_valid, res_upd, res_retry;
  logic [17:0] cas_expect, cas_new;
  logic [7:0] res_flags;
  logic [9:0] res_ext;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pte_flag_updater u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11: legal codes {kind, rd_cap, wr_cap}
  function automatic logic [3:0] code_of(int i);
    case (i)
      0: return 4'b0000; 1: return 4'b0100; 2: return 4'b0110;
      3: return 4'b1000; 4: return 4'b1001; 5: return 4'b1100;
      6: return 4'b1101; 7: return 4'b1110; default: return 4'b1111;
    endcase
  endfunction

  task automatic run_tx(logic [7:0] f, logic [9:0] e, logic [3:0] acc, logic tg,
                        logic nx, logic ok, int stall, bit hold_res);
    logic [9:0] ee; logic wr, na, nd, ncd, upd;
    logic [7:0] xf; logic [9:0] xe;
    ee  = nx ? 10'b1110000000 : e;
    wr  = acc[3];
    na  = !f[6];
    nd  = wr && !f[7];
    ncd = ee[9] && !ee[7] && wr && acc[0] && tg;
    upd = na || nd || ncd;
    xf = f; xe = ee;
    if (upd) xf[6] = 1'b1;
    if (nd)  xf[7] = 1'b1;
    if (ncd) xe[7] = 1'b1;

    @(negedge clk);
    in_flags = f; in_ext = e; in_acc = acc; in_tag = tg; no_ext = nx; in_valid = 1'b1;
    check("R10 ready idle", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    if (upd) begin
      check("R7 cas_valid", 32'(cas_valid), 1);
      check("R7 cas_expect", 32'(cas_expect), 32'({ee, f}));
      check("R7 cas_new", 32'(cas_new), 32'({xe, xf}));
      check("R10 busy", 32'(in_ready), 0);
      for (int s = 0; s < stall; s++) @(negedge clk);
      check("R7 cas held", 32'({cas_valid, cas_new}), 32'({1'b1, xe, xf}));
      cas_ready = 1'b1;
      @(negedge clk);
      cas_ready = 1'b0;
      check("R7 cas taken", 32'(cas_valid), 0);
      mem_done = 1'b1; mem_ok = ok;
      @(negedge clk);
      mem_done = 1'b0;
      check("R8 retry", 32'(res_retry), 32'(!ok));
    end else begin
      check("R6 no swap", 32'(cas_valid), 0);
      check("R6 retry clear", 32'(res_retry), 0);
    end
    check("R6 res_valid", 32'(res_valid), 1);
    check("R6 res_upd", 32'(res_upd), 32'(upd));
    check("R1 A bit", 32'(res_flags[6]), 32'(xf[6]));
    check("R2 D bit", 32'(res_flags[7]), 32'(xf[7]));
    check(tg ? "R3 CD bit" : "R4 CD bit", 32'(res_ext[7]), 32'(xe[7]));
    check("R5 other flags", 32'(res_flags[5:0]), 32'(f[5:0]));
    check(nx ? "R9 ext" : "R5 ext", 32'(res_ext), 32'(xe));
    if (hold_res) begin
      @(negedge clk);
      check("R10 res held", 32'({res_valid, res_flags, res_ext}), 32'({1'b1, xf, xe}));
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R10 res taken", 32'(res_valid), 0);
  endtask

  initial begin
    int cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset ready", 32'(in_ready), 1);
    check("R6 reset cas", 32'(cas_valid), 0);
    check("R10 reset res", 32'(res_valid), 0);
    for (int nx = 0; nx < 2; nx++)
      for (int ci = 0; ci < 9; ci++)
        for (int tg = 0; tg < 2; tg++)
          for (int ad = 0; ad < 4; ad++)
            for (int wc = 0; wc < 4; wc++)
              for (int ot = 0; ot < 2; ot++) begin
                logic [7:0] f; logic [9:0] e;
                f = {ad[1], ad[0], (ot != 0) ? 6'b010111 : 6'b101001};
                e = {wc[1], ot[0], wc[0], (ot != 0) ? 7'h55 : 7'h2A};
                run_tx(f, e, code_of(ci), tg[0], nx[0], cnt[0] ^ cnt[2], cnt % 3, cnt[1]);
                cnt++;
              end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule